// File: doc/BRIEF.md
# Floppy Write-Mode Serializer and Latch

This block sits on the controller side of a floppy interface. It decodes a page of sixteen CPU soft-switch addresses and keeps the motor, drive-select and two mode switches. The two mode switches, called Q7 and Q6 here, together pick one of four behaviours: read, sense write protect, write, and load the write latch. Any access to a switch address sets or clears one switch. Address bits 3:1 pick the switch and address bit 0 gives its new value.

In write mode, a CPU store loads the write latch. A later access to the shift-start address sends the latch out serially, MSB first, on a drive write-data line. The line uses one bit slot per eight ticks of a reference enable (the 2 MHz reference divided down, so a byte lasts 64 ticks, or 32 CPU cycles). A 1 bit toggles the line once, at the start of its slot. A 0 bit leaves the line unchanged. At every byte boundary the shifter takes whatever the latch holds, so software that misses the 32-cycle window repeats the last byte instead of stalling the shifter.

A read access that leaves the mode in sense-write-protect returns the protect input in bit 7 of the read data.

Top module: `fdc_write_shifter`

## Requirements
- R1: A bus access is accepted only in a cycle where `bus_strobe` and `dev_sel` are both high. A strobe without the device select, or the device select without a strobe, changes no switch, no read data and no latch.
- R2: On an accepted access, `bus_addr[3:1]` picks the switch and `bus_addr[0]` is its new value. Switch 4 is the motor (`motor_on`), 5 is drive-2 select (`drive2_sel`), 6 is Q6 and 7 is Q7. Switches 0 to 3 (stepper phases) have no effect on any output of this block.
- R3: `wr_req` is high exactly when Q7 and the motor switch are both set.
- R4: The mode is {Q7,Q6}: 00 read, 01 sense write protect, 10 write, 11 load latch. An accepted read (`bus_we`=0) sets `bus_rdata` on the next cycle. The value is {`wprot_in`,7'b0} if the mode after that access's own switch update is 01, and 8'h00 otherwise. `bus_rdata` holds its value until the next accepted read, and bits 6:0 are always zero.
- R5: An accepted write (`bus_we`=1) to address 4'hD while Q7 is already set loads `bus_wdata` into the write latch. The same store with Q7 clear leaves the latch unchanged.
- R6: An accepted access to address 4'hC while `wr_req` is high and the shifter is idle starts shifting the latch contents. No other access starts the shifter.
- R7: Each bit occupies 8 `ref_tick` pulses and bits leave MSB first. A 1 bit toggles `wr_data` on the first tick of its slot. A 0 bit leaves `wr_data` unchanged. `wr_data` never changes except on a tick while `wr_req` is high.
- R8: After the eighth bit, the shifter continues with no gap from the latch. This is the newly stored byte if one arrived during the byte, and otherwise the same byte again.
- R9: While `wr_req` is low, the shifter stops and `wr_data` holds its level. It stays idle until a new start access.
- R10: Reset (synchronous, active high) clears Q6, Q7, the motor and drive-2 switches, the write latch, the shift register, `wr_data` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable at the 2 MHz reference rate |
| bus_strobe | input | 1 | Single-cycle bus access strobe |
| dev_sel | input | 1 | Device select qualifying the strobe |
| bus_addr | input | 4 | Soft-switch address within the page |
| bus_we | input | 1 | 1 = store, 0 = read |
| bus_wdata | input | 8 | CPU store data |
| bus_rdata | output | 8 | Registered read data (write-protect status in bit 7) |
| wprot_in | input | 1 | Write-protect sense from the drive |
| motor_on | output | 1 | Motor switch state |
| drive2_sel | output | 1 | Drive-2 select switch state |
| wr_req | output | 1 | Write request to the drive |
| wr_data | output | 1 | Serial write-data line (a toggle encodes a 1) |

## Verification
A wrong switch bit shows within one cycle on `motor_on`, `drive2_sel`, `wr_req` or the next read's `bus_rdata`. A wrong latch or shift register shows on `wr_data` within one byte time (64 reference ticks): either a missing toggle, an extra toggle, or a toggle placed in a non-first tick of a slot. A wrong bit or tick counter shows as a byte boundary in the wrong place, which surfaces at the latest when the reloaded byte starts. Every one of the 256 byte values is shifted out and decoded from the toggle positions, and the reload and mid-byte latch update cases are checked across two consecutive bytes.

// File: rtl/fdc_wr_pkg.sv
package fdc_wr_pkg;

    localparam int unsigned ADDR_W = 4;

    localparam logic [2:0] SW_MOTOR  = 3'd4;
    localparam logic [2:0] SW_DRIVE2 = 3'd5;
    localparam logic [2:0] SW_Q6     = 3'd6;
    localparam logic [2:0] SW_Q7     = 3'd7;

    localparam logic [ADDR_W-1:0] A_SHIFT_GO  = 4'hC;
    localparam logic [ADDR_W-1:0] A_LATCH_LD  = 4'hD;

    typedef enum logic [1:0] {
        MODE_READ  = 2'b00,
        MODE_SENSE = 2'b01,
        MODE_WRITE = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;

    typedef struct packed {
        logic q7;
        logic q6;
        logic motor;
        logic drive2;
    } sw_t;

endpackage

// File: rtl/fdc_switch_bank.sv
module fdc_switch_bank
    import fdc_wr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wprot,
    output sw_t               sw,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] latch,
    output logic              start
);

    typedef struct packed {
        sw_t               sw;
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] latch;
    } bank_t;

    bank_t cur_q, nxt_d;
    mode_e mode_after;

    always_comb begin
        nxt_d = cur_q;
        if (acc) begin
            unique case (addr[3:1])
                SW_MOTOR:  nxt_d.sw.motor  = addr[0];
                SW_DRIVE2: nxt_d.sw.drive2 = addr[0];
                SW_Q6:     nxt_d.sw.q6     = addr[0];
                SW_Q7:     nxt_d.sw.q7     = addr[0];
                default:   ;
            endcase
        end
        mode_after = mode_e'({nxt_d.sw.q7, nxt_d.sw.q6});
        if (acc && !we) begin
            nxt_d.rdata = '0;
            if (mode_after == MODE_SENSE) begin
                nxt_d.rdata[DATA_W-1] = wprot;
            end
        end
        if (acc && we && addr == A_LATCH_LD && cur_q.sw.q7) begin
            nxt_d.latch = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sw    = cur_q.sw;
    assign rdata = cur_q.rdata;
    assign latch = cur_q.latch;
    assign start = acc && addr == A_SHIFT_GO && cur_q.sw.q7 && cur_q.sw.motor;

endmodule

// File: rtl/fdc_bit_shifter.sv
module fdc_bit_shifter #(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned TICKS_PER_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              run_en,
    input  logic              start,
    input  logic [DATA_W-1:0] latch,
    output logic              wr_data
);

    localparam int unsigned TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(TICKS_PER_BIT - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

    typedef struct packed {
        logic              active;
        logic [DATA_W-1:0] sreg;
        logic [BW-1:0]     bitcnt;
        logic [TW-1:0]     tickcnt;
        logic              wdat;
    } shf_t;

    shf_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!run_en) begin
            nxt_d.active = 1'b0;
        end else if (!cur_q.active) begin
            if (start) begin
                nxt_d.active  = 1'b1;
                nxt_d.sreg    = latch;
                nxt_d.bitcnt  = '0;
                nxt_d.tickcnt = '0;
            end
        end else if (ref_tick) begin
            if (cur_q.tickcnt == '0 && cur_q.sreg[DATA_W-1]) begin
                nxt_d.wdat = ~cur_q.wdat;
            end
            if (cur_q.tickcnt == LAST_TICK) begin
                nxt_d.tickcnt = '0;
                if (cur_q.bitcnt == LAST_BIT) begin
                    nxt_d.sreg   = latch;
                    nxt_d.bitcnt = '0;
                end else begin
                    nxt_d.sreg   = cur_q.sreg << 1;
                    nxt_d.bitcnt = cur_q.bitcnt + 1'b1;
                end
            end else begin
                nxt_d.tickcnt = cur_q.tickcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign wr_data = cur_q.wdat;

endmodule

// File: rtl/fdc_write_shifter.sv
module fdc_write_shifter
    import fdc_wr_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned TICKS_PER_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_strobe,
    input  logic              dev_sel,
    input  logic [3:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wprot_in,
    output logic              motor_on,
    output logic              drive2_sel,
    output logic              wr_req,
    output logic              wr_data
);

    logic              acc;
    sw_t               sw;
    logic [DATA_W-1:0] latch;
    logic              start;

    assign acc = bus_strobe && dev_sel;

    fdc_switch_bank #(
        .DATA_W (DATA_W)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .wprot (wprot_in),
        .sw    (sw),
        .rdata (bus_rdata),
        .latch (latch),
        .start (start)
    );

    assign motor_on   = sw.motor;
    assign drive2_sel = sw.drive2;
    assign wr_req     = sw.q7 && sw.motor;

    fdc_bit_shifter #(
        .DATA_W        (DATA_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .run_en   (wr_req),
        .start    (start),
        .latch    (latch),
        .wr_data  (wr_data)
    );

endmodule

// File: rtl/fdc_write_shifter_chk.sv
module fdc_write_shifter_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_tick,
    input logic              bus_strobe,
    input logic              dev_sel,
    input logic [3:0]        bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              motor_on,
    input logic              drive2_sel,
    input logic              wr_req,
    input logic              wr_data
);

    p_ignore_unselected_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && !dev_sel) |=> (motor_on == $past(motor_on) &&
                                      drive2_sel == $past(drive2_sel) &&
                                      wr_req == $past(wr_req)));

    p_stepper_no_effect_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && dev_sel && !bus_addr[3]) |=> (motor_on == $past(motor_on) &&
                                                     drive2_sel == $past(drive2_sel) &&
                                                     wr_req == $past(wr_req)));

    p_req_needs_motor_r3: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> motor_on);

    p_rdata_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-2:0] == '0);

    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata != $past(bus_rdata)) |-> $past(bus_strobe && dev_sel && !bus_we));

    p_wdata_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_data != $past(wr_data)) |-> ($past(ref_tick) && $past(wr_req)));

endmodule

bind fdc_write_shifter fdc_write_shifter_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_tick   (ref_tick),
    .bus_strobe (bus_strobe),
    .dev_sel    (dev_sel),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .motor_on   (motor_on),
    .drive2_sel (drive2_sel),
    .wr_req     (wr_req),
    .wr_data    (wr_data)
);

// File: tb/tb_fdc_write_shifter.sv
module tb_fdc_write_shifter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic       bus_strobe = 1'b0;
    logic       dev_sel = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wprot_in = 1'b0;
    logic       motor_on, drive2_sel, wr_req, wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fdc_write_shifter dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_strobe(bus_strobe),
        .dev_sel(dev_sel), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wprot_in(wprot_in),
        .motor_on(motor_on), .drive2_sel(drive2_sel), .wr_req(wr_req),
        .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic raw_access(input logic [3:0] a, input logic we, input logic [7:0] d,
                              input logic stb, input logic sel);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d; bus_strobe = stb; dev_sel = sel;
        @(negedge clk);
        bus_strobe = 1'b0; dev_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        raw_access(a, 1'b0, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        raw_access(a, 1'b1, d, 1'b1, 1'b1);
    endtask

    task automatic tick();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // ticks [from,to) of a byte; toggles decoded into obs, off-slot toggles counted
    task automatic shift_part(input int from, input int to,
                              inout logic [7:0] obs, inout int stray);
        for (int k = from; k < to; k++) begin
            logic prev;
            prev = wr_data;
            tick();
            if (wr_data != prev) begin
                if (k % 8 == 0) obs[7 - k / 8] = 1'b1;
                else stray++;
            end
        end
    endtask

    task automatic count_toggles(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            logic prev;
            prev = wr_data;
            tick();
            if (wr_data != prev) cnt++;
        end
    endtask

    initial begin
        logic [7:0] obs;
        int stray;
        int cnt;
        int bad_bytes;

        repeat (3) @(negedge clk);
        // R10: reset state
        check(wr_req == 0 && motor_on == 0 && drive2_sel == 0, "R10 reset switches",
              {wr_req, motor_on, drive2_sel}, 0);
        check(wr_data == 0 && bus_rdata == 0, "R10 reset data", {wr_data, bus_rdata}, 0);
        rst = 1'b0;

        // R1: unqualified strobe / select alone
        raw_access(4'h9, 1'b0, 8'h00, 1'b1, 1'b0);
        check(motor_on == 0, "R1 strobe without select", motor_on, 0);
        raw_access(4'h9, 1'b0, 8'h00, 1'b0, 1'b1);
        check(motor_on == 0, "R1 select without strobe", motor_on, 0);

        // R2: switch decode
        rd(4'h9);
        check(motor_on == 1, "R2 motor on via 9", motor_on, 1);
        rd(4'hB);
        check(drive2_sel == 1, "R2 drive2 on via B", drive2_sel, 1);
        rd(4'hA);
        check(drive2_sel == 0, "R2 drive2 off via A", drive2_sel, 0);
        rd(4'hF);
        for (int a = 0; a < 8; a++) begin
            rd(4'(a));
            wr(4'(a), 8'hFF);
        end
        check(motor_on == 1 && drive2_sel == 0 && wr_req == 1, "R2 stepper addresses ignored",
              {motor_on, drive2_sel, wr_req}, 3'b101);

        // R3: write request = Q7 and motor
        rd(4'h8);
        check(wr_req == 0, "R3 motor off drops request", wr_req, 0);
        rd(4'h9);
        check(wr_req == 1, "R3 motor on with Q7", wr_req, 1);
        rd(4'hE);
        check(wr_req == 0, "R3 Q7 off drops request", wr_req, 0);

        // R4: write-protect sense
        wprot_in = 1'b1;
        rd(4'hE);
        check(bus_rdata == 8'h00, "R4 read mode returns zero", bus_rdata, 8'h00);
        rd(4'hD);
        check(bus_rdata == 8'h80, "R4 sense protected via D", bus_rdata, 8'h80);
        wr(4'h9, 8'h11);
        check(bus_rdata == 8'h80, "R4 rdata held over store", bus_rdata, 8'h80);
        wprot_in = 1'b0;
        rd(4'hE);
        check(bus_rdata == 8'h00, "R4 sense unprotected", bus_rdata, 8'h00);
        wprot_in = 1'b1;
        rd(4'hE);
        check(bus_rdata == 8'h80, "R4 sense protected via E", bus_rdata, 8'h80);
        rd(4'hC);
        check(bus_rdata == 8'h00, "R4 read mode after C", bus_rdata, 8'h00);
        rd(4'hF);
        check(bus_rdata == 8'h00, "R4 write mode read", bus_rdata, 8'h00);
        rd(4'hD);
        check(bus_rdata == 8'h00, "R4 load mode read", bus_rdata, 8'h00);
        wprot_in = 1'b0;

        // R5: store with Q7 clear leaves latch at reset value 0
        rd(4'hE);
        wr(4'hD, 8'hA5);
        rd(4'hF);
        rd(4'hC);
        obs = '0; stray = 0;
        shift_part(0, 64, obs, stray);
        check(obs == 8'h00 && stray == 0, "R5 latch unchanged with Q7 clear", obs, 8'h00);
        rd(4'hE);

        // R6: no start without the C access
        rd(4'hF);
        wr(4'hD, 8'hFF);
        count_toggles(64, cnt);
        check(cnt == 0, "R6 no shifting before start", cnt, 0);
        rd(4'hE);

        // R6/R7: all byte values
        bad_bytes = 0;
        for (int b = 0; b < 256; b++) begin
            rd(4'hF);
            wr(4'hD, 8'(b));
            rd(4'hC);
            obs = '0; stray = 0;
            shift_part(0, 64, obs, stray);
            if (obs != 8'(b) || stray != 0) begin
                bad_bytes++;
                check(1'b0, "R7 byte pattern", {obs, 8'(stray)}, {8'(b), 8'h00});
            end
            rd(4'hE);
        end
        check(bad_bytes == 0, "R6 R7 all bytes shifted", bad_bytes, 0);

        // R8: reload of same byte, then mid-byte latch update
        rd(4'hF);
        wr(4'hD, 8'h96);
        rd(4'hC);
        obs = '0; stray = 0;
        shift_part(0, 64, obs, stray);
        check(obs == 8'h96 && stray == 0, "R8 first byte", obs, 8'h96);
        obs = '0; stray = 0;
        shift_part(0, 64, obs, stray);
        check(obs == 8'h96 && stray == 0, "R8 reload same byte", obs, 8'h96);
        obs = '0; stray = 0;
        shift_part(0, 20, obs, stray);
        wr(4'hD, 8'h5A);
        shift_part(20, 64, obs, stray);
        check(obs == 8'h96 && stray == 0, "R8 byte in flight kept", obs, 8'h96);
        obs = '0; stray = 0;
        shift_part(0, 64, obs, stray);
        check(obs == 8'h5A && stray == 0, "R8 new byte at boundary", obs, 8'h5A);

        // R9: stop mid byte, stay idle after Q7 returns
        obs = '0; stray = 0;
        shift_part(0, 12, obs, stray);
        rd(4'hE);
        count_toggles(64, cnt);
        check(cnt == 0 && wr_req == 0, "R9 stopped when request low", cnt, 0);
        rd(4'hF);
        count_toggles(64, cnt);
        check(cnt == 0, "R9 idle until new start", cnt, 0);
        rd(4'hC);
        obs = '0; stray = 0;
        shift_part(0, 64, obs, stray);
        check(obs == 8'h5A && stray == 0, "R9 restart from latch", obs, 8'h5A);

        // R10: reset in the middle of shifting
        shift_part(0, 5, obs, stray);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check(wr_req == 0 && motor_on == 0 && wr_data == 0 && bus_rdata == 0,
              "R10 reset mid shift", {wr_req, motor_on, wr_data}, 0);
        rd(4'h9);
        rd(4'hF);
        rd(4'hC);
        obs = '0; stray = 0;
        shift_part(0, 64, obs, stray);
        check(obs == 8'h00 && stray == 0, "R10 latch cleared by reset", obs, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule